// File: doc/BRIEF.md
# Interrupt Request Controller for an 8-bit Microcontroller Core

This block gathers interrupt requests from six sources: two external request lines, three timers and a serial port. It masks them through a software-visible enable register, resolves simultaneous requests by a fixed order, and hands the CPU core one request at a time as a vector address plus a request strobe. Flags are sampled only on the machine-cycle strobe. The first two timers' overflow flags pass through one extra sampling stage, because those flags become valid late in the overflow cycle. The third timer's overflow flag is taken on the first sample.

The CPU accepts a request with an acknowledge pulse. At that moment the controller emits one-cycle clear pulses to the flag owners whose flags are cleared by hardware. Those are the first two timers, and the external lines that are in edge mode. The serial flag and the third timer's two flags stay set, and software must clear them. From acknowledge until a return-from-interrupt pulse the controller is in service and issues no further request.

Top module: `mcu_irq_ctrl`

## Requirements
- R1: The enable register is read back on `en_rdata` and written in full by `en_wr`/`en_wdata`. Bit 7 is the global enable. Bits 0 to 5 enable, in this order, EXT0, TMR0, EXT1, TMR1, SER and TMR2. All bits reset to 0.
- R2: Bit 6 of the enable register always reads 0. Writing 1 to it has no effect.
- R3: A source whose own enable bit is 0 never raises `irq_req`. With bit 7 at 0, no source raises `irq_req`, whatever the other bits hold.
- R4: The requests from EXT0, EXT1, SER and TMR2 are captured on the first `mc_tick` after the flag rises, and `irq_req` rises on the second `mc_tick`. `irq_req` only ever rises in a cycle with `mc_tick` high. The TMR2 request is the OR of `t2_ovf` and `t2_ext`.
- R5: Requests from TMR0 and TMR1 need one more `mc_tick`: `irq_req` rises on the third tick.
- R6: When several enabled requests are pending, the one served first is chosen in the fixed order EXT0, TMR0, EXT1, TMR1, SER, TMR2, highest first.
- R7: `irq_vector` is 0x0003 + 8 × position in the R6 order: 0x0003, 0x000B, 0x0013, 0x001B, 0x0023, 0x002B.
- R8: Once raised, `irq_req` stays high and `irq_vector` stays unchanged until the cycle in which `irq_ack` is high.
- R9: In the acknowledge cycle, exactly one of `clr_t0`/`clr_t1` pulses for a TMR0/TMR1 request. For EXT0/EXT1, `clr_ext0`/`clr_ext1` pulses only when `ext0_edge`/`ext1_edge` is 1. No clear pulses for SER, TMR2 or a level-mode external request.
- R10: SER and TMR2 requests are not cleared by the acknowledge. If software leaves the flag set, the same vector is requested again after return.
- R11: After an acknowledge, `irq_req` stays low until a `reti` pulse. After that pulse, a still-pending request is issued on the next `mc_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mc_tick | input | 1 | Machine-cycle strobe, one clock wide |
| ext0_flag | input | 1 | External request 0 flag |
| ext1_flag | input | 1 | External request 1 flag |
| ext0_edge | input | 1 | 1: external request 0 is edge mode (cleared by hardware) |
| ext1_edge | input | 1 | 1: external request 1 is edge mode |
| t0_ovf | input | 1 | Timer 0 overflow flag |
| t1_ovf | input | 1 | Timer 1 overflow flag |
| t2_ovf | input | 1 | Timer 2 overflow flag |
| t2_ext | input | 1 | Timer 2 external flag |
| ser_flag | input | 1 | Serial port flag (receive or transmit) |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | 8 | Enable register write data |
| en_rdata | output | 8 | Enable register read data |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vector | output | 16 | Vector address of the request |
| irq_ack | input | 1 | CPU acknowledge |
| reti | input | 1 | Return-from-interrupt pulse |
| clr_ext0 | output | 1 | Clear pulse for the external 0 flag |
| clr_ext1 | output | 1 | Clear pulse for the external 1 flag |
| clr_t0 | output | 1 | Clear pulse for the timer 0 flag |
| clr_t1 | output | 1 | Clear pulse for the timer 1 flag |

## Verification
Each latency is counted in machine-cycle strobes, never in clocks. A single-stage source must still show `irq_req` low after its first tick and high after its second. A TMR0/TMR1 source must still be low after two ticks and high after three. Clear pulses are combinational on the acknowledge, so they are sampled inside the acknowledge cycle. The request after `reti` is due on the very next tick. The bench makes every tick a one-clock strobe driven on the falling edge, and reads the outputs at the following falling edge, after the register stage has settled.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NSRC     = 6;
  localparam int EN_W     = 8;
  localparam int GLB_BIT  = 7;
  localparam int RSV_BIT  = 6;
  localparam int VEC_W    = 16;

  // source positions double as priority rank (0 = highest) and enable bit
  typedef enum logic [2:0] {
    SRC_EXT0 = 3'd0,
    SRC_TMR0 = 3'd1,
    SRC_EXT1 = 3'd2,
    SRC_TMR1 = 3'd3,
    SRC_SER  = 3'd4,
    SRC_TMR2 = 3'd5
  } src_e;

  // sources whose flag is valid only late in its cycle: one extra stage
  localparam logic [NSRC-1:0] LATE_MASK = (NSRC'(1) << SRC_TMR0) | (NSRC'(1) << SRC_TMR1);
  // sources always cleared by hardware on acknowledge
  localparam logic [NSRC-1:0] HWCLR_FIXED = (NSRC'(1) << SRC_TMR0) | (NSRC'(1) << SRC_TMR1);
endpackage

// File: rtl/irqc_sampler.sv
module irqc_sampler #(
  parameter int              NSRC = 6,
  parameter logic [NSRC-1:0] LATE = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [NSRC-1:0] raw,
  input  logic [NSRC-1:0] kill,
  output logic [NSRC-1:0] smp
);
  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_src
      logic smp_d, smp_q;
      if (LATE[i]) begin : g_late
        logic dly_d, dly_q;
        always_comb begin
          dly_d = dly_q;
          if (kill[i])   dly_d = 1'b0;
          else if (tick) dly_d = raw[i];
        end
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) dly_q <= 1'b0;
          else        dly_q <= dly_d;
        end
        always_comb begin
          smp_d = smp_q;
          if (kill[i])   smp_d = 1'b0;
          else if (tick) smp_d = dly_q;
        end
      end else begin : g_early
        always_comb begin
          smp_d = smp_q;
          if (kill[i])   smp_d = 1'b0;
          else if (tick) smp_d = raw[i];
        end
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) smp_q <= 1'b0;
        else        smp_q <= smp_d;
      end
      assign smp[i] = smp_q;
    end
  endgenerate
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int NSRC       = 6,
  parameter int VEC_W      = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input  logic [NSRC-1:0]  pend,
  output logic             any,
  output logic [NSRC-1:0]  onehot,
  output logic [VEC_W-1:0] vector
);
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [IDX_W-1:0] idx;
  logic             found;

  always_comb begin
    onehot = '0;
    idx    = '0;
    found  = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (pend[i] && !found) begin
        onehot[i] = 1'b1;
        idx       = IDX_W'(i);
        found     = 1'b1;
      end
    end
    any    = found;
    vector = VEC_W'(VEC_BASE) + VEC_W'(VEC_STRIDE) * VEC_W'(idx);
  end
endmodule

// File: rtl/irqc_seq.sv
module irqc_seq #(
  parameter int NSRC  = 6,
  parameter int VEC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             any,
  input  logic [NSRC-1:0]  onehot,
  input  logic [VEC_W-1:0] vec_in,
  input  logic [NSRC-1:0]  hwclr,
  input  logic             ack,
  input  logic             reti,
  output logic             req,
  output logic [VEC_W-1:0] vector,
  output logic [NSRC-1:0]  kill
);
  logic             req_d, req_q;
  logic             svc_d, svc_q;
  logic [VEC_W-1:0] vec_d, vec_q;
  logic [NSRC-1:0]  sel_d, sel_q;
  logic             fire;

  always_comb begin
    req_d = req_q;
    svc_d = svc_q;
    vec_d = vec_q;
    sel_d = sel_q;
    fire  = req_q & ack;
    if (reti && svc_q) svc_d = 1'b0;
    if (fire) begin
      req_d = 1'b0;
      svc_d = 1'b1;
    end else if (tick && !req_q && !svc_q && any) begin
      req_d = 1'b1;
      vec_d = vec_in;
      sel_d = onehot;
    end
    kill = fire ? (sel_q & hwclr) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      svc_q <= 1'b0;
      vec_q <= '0;
      sel_q <= '0;
    end else begin
      req_q <= req_d;
      svc_q <= svc_d;
      vec_q <= vec_d;
      sel_q <= sel_d;
    end
  end

  assign req    = req_q;
  assign vector = vec_q;

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !ack) |=> (req_q && $stable(vec_q)));
  assert_quiet_in_service_R11: assert property (@(posedge clk) disable iff (!rst_n)
    svc_q |-> !req_q);
  assert_rise_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> $past(tick));
  assert_single_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(kill) && ((kill & ~sel_q) == '0));
endmodule

// File: rtl/mcu_irq_ctrl.sv
module mcu_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mc_tick,
  input  logic             ext0_flag,
  input  logic             ext1_flag,
  input  logic             ext0_edge,
  input  logic             ext1_edge,
  input  logic             t0_ovf,
  input  logic             t1_ovf,
  input  logic             t2_ovf,
  input  logic             t2_ext,
  input  logic             ser_flag,
  input  logic             en_wr,
  input  logic [EN_W-1:0]  en_wdata,
  output logic [EN_W-1:0]  en_rdata,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vector,
  input  logic             irq_ack,
  input  logic             reti,
  output logic             clr_ext0,
  output logic             clr_ext1,
  output logic             clr_t0,
  output logic             clr_t1
);
  localparam logic [EN_W-1:0] EN_KEEP = ~(EN_W'(1) << RSV_BIT);

  // reset: asynchronous assert, synchronous release
  logic rs_meta_q, rs_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta_q <= 1'b0;
      rs_q      <= 1'b0;
    end else begin
      rs_meta_q <= 1'b1;
      rs_q      <= rs_meta_q;
    end
  end

  // enable register
  logic [EN_W-1:0] en_d, en_q;
  always_comb begin
    en_d = en_q;
    if (en_wr) en_d = en_wdata & EN_KEEP;
  end
  always_ff @(posedge clk or negedge rs_q) begin
    if (!rs_q) en_q <= '0;
    else       en_q <= en_d;
  end
  assign en_rdata = en_q;

  // request vector in priority order
  logic [NSRC-1:0] raw, smp, pend, onehot, kill, hwclr;
  logic            any;
  logic [VEC_W-1:0] vec_sel;

  always_comb begin
    raw           = '0;
    raw[SRC_EXT0] = ext0_flag;
    raw[SRC_TMR0] = t0_ovf;
    raw[SRC_EXT1] = ext1_flag;
    raw[SRC_TMR1] = t1_ovf;
    raw[SRC_SER]  = ser_flag;
    raw[SRC_TMR2] = t2_ovf | t2_ext;
    hwclr           = HWCLR_FIXED;
    hwclr[SRC_EXT0] = ext0_edge;
    hwclr[SRC_EXT1] = ext1_edge;
    pend = smp & en_q[NSRC-1:0] & {NSRC{en_q[GLB_BIT]}};
  end

  irqc_sampler #(.NSRC(NSRC), .LATE(LATE_MASK)) u_sampler (
    .clk(clk), .rst_n(rs_q), .tick(mc_tick), .raw(raw), .kill(kill), .smp(smp)
  );

  irqc_prio #(.NSRC(NSRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)) u_prio (
    .pend(pend), .any(any), .onehot(onehot), .vector(vec_sel)
  );

  irqc_seq #(.NSRC(NSRC), .VEC_W(VEC_W)) u_seq (
    .clk(clk), .rst_n(rs_q), .tick(mc_tick), .any(any), .onehot(onehot),
    .vec_in(vec_sel), .hwclr(hwclr), .ack(irq_ack), .reti(reti),
    .req(irq_req), .vector(irq_vector), .kill(kill)
  );

  assign clr_ext0 = kill[SRC_EXT0];
  assign clr_ext1 = kill[SRC_EXT1];
  assign clr_t0   = kill[SRC_TMR0];
  assign clr_t1   = kill[SRC_TMR1];

  assert_winner_pending_R6: assert property (@(posedge clk) disable iff (!rs_q)
    any |-> ($onehot(onehot) && ((onehot & ~pend) == '0) && ((pend & (onehot - 1'b1)) == '0)));
  assert_rsv_bit_zero_R2: assert property (@(posedge clk) disable iff (!rs_q)
    en_wr |=> (en_rdata[RSV_BIT] == 1'b0));
  assert_global_mask_R3: assert property (@(posedge clk) disable iff (!rs_q)
    !en_q[GLB_BIT] |-> !any);
endmodule

// File: tb/mcu_irq_ctrl_bench.sv
module mcu_irq_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n, mc_tick, ext0_flag, ext1_flag, ext0_edge, ext1_edge;
  logic t0_ovf, t1_ovf, t2_ovf, t2_ext, ser_flag, en_wr, irq_ack, reti;
  logic [7:0]  en_wdata, en_rdata;
  logic        irq_req, clr_ext0, clr_ext1, clr_t0, clr_t1;
  logic [15:0] irq_vector;
  int nchk = 0, nfail = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mcu_irq_ctrl u_mcu_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .ext0_flag(ext0_flag), .ext1_flag(ext1_flag),
    .ext0_edge(ext0_edge), .ext1_edge(ext1_edge), .t0_ovf(t0_ovf), .t1_ovf(t1_ovf),
    .t2_ovf(t2_ovf), .t2_ext(t2_ext), .ser_flag(ser_flag), .en_wr(en_wr), .en_wdata(en_wdata),
    .en_rdata(en_rdata), .irq_req(irq_req), .irq_vector(irq_vector), .irq_ack(irq_ack),
    .reti(reti), .clr_ext0(clr_ext0), .clr_ext1(clr_ext1), .clr_t0(clr_t0), .clr_t1(clr_t1)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) mc_tick = 1'b1;
    @(negedge clk) mc_tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr_en(input logic [7:0] v);
    @(negedge clk) begin en_wr = 1'b1; en_wdata = v; end
    @(negedge clk) en_wr = 1'b0;
  endtask

  // acknowledge; returns clear pulses seen in the ack cycle as {t1,t0,x1,x0}
  task automatic ack(output logic [3:0] clrs);
    @(negedge clk) irq_ack = 1'b1;
    #1 clrs = {clr_t1, clr_t0, clr_ext1, clr_ext0};
    @(negedge clk) irq_ack = 1'b0;
  endtask

  task automatic do_reti();
    @(negedge clk) reti = 1'b1;
    @(negedge clk) reti = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset en_rdata", en_rdata, 0);
    chk("R8 reset irq_req", irq_req, 0);
    chk("R9 reset clears", {clr_t1, clr_t0, clr_ext1, clr_ext0}, 0);
  endtask

  task automatic t_enreg();
    wr_en(8'hFF); chk("R2 bit6 reads 0 after 0xFF", en_rdata, 8'hBF);
    wr_en(8'h55); chk("R2 write 0x55", en_rdata, 8'h15);
    wr_en(8'h8A); chk("R1 write 0x8A", en_rdata, 8'h8A);
    wr_en(8'h00);
  endtask

  task automatic t_tmr2_early();
    logic [3:0] c;
    wr_en(8'hA0);
    t2_ext = 1'b1;
    tick(); chk("R4 tmr2 not yet after 1 tick", irq_req, 0);
    tick(); chk("R4 tmr2 req after 2 ticks", irq_req, 1);
    chk("R7 tmr2 vector", irq_vector, 16'h002B);
    ticks(2); repeat (3) @(negedge clk);
    chk("R8 req held", irq_req, 1);
    chk("R8 vector held", irq_vector, 16'h002B);
    ack(c); chk("R9 no clear for tmr2", c, 0);
    chk("R11 req drops on ack", irq_req, 0);
    ticks(3); chk("R11 quiet in service", irq_req, 0);
    do_reti(); tick();
    chk("R10 tmr2 re-requests", irq_req, 1);
    chk("R10 tmr2 vector again", irq_vector, 16'h002B);
    ack(c); t2_ext = 1'b0; tick(); do_reti(); ticks(3);
    chk("R10 quiet after sw clear", irq_req, 0);
    t2_ovf = 1'b1; ticks(2);
    chk("R4 tmr2 overflow flag also requests", irq_req, 1);
    ack(c); t2_ovf = 1'b0; tick(); do_reti(); ticks(2);
  endtask

  task automatic t_tmr0_late();
    logic [3:0] c;
    wr_en(8'h82);
    t0_ovf = 1'b1;
    ticks(2); chk("R5 tmr0 not yet after 2 ticks", irq_req, 0);
    tick();   chk("R5 tmr0 req after 3 ticks", irq_req, 1);
    chk("R7 tmr0 vector", irq_vector, 16'h000B);
    ack(c); chk("R9 clr_t0 on ack", c, 4'b0100);
    t0_ovf = 1'b0;
    do_reti(); ticks(3);
    chk("R9 no request after hw clear", irq_req, 0);
  endtask

  task automatic t_priority();
    logic [3:0] c;
    wr_en(8'hBF);
    ext0_edge = 1'b1; ext1_edge = 1'b1;
    ext0_flag = 1'b1; ext1_flag = 1'b1; t0_ovf = 1'b1; t1_ovf = 1'b1; ser_flag = 1'b1; t2_ext = 1'b1;
    ticks(2);
    chk("R6 ext0 first", irq_vector, 16'h0003);
    ack(c); chk("R9 clr_ext0 edge mode", c, 4'b0001); ext0_flag = 1'b0;
    tick(); do_reti(); tick();
    chk("R6 tmr0 second", irq_vector, 16'h000B);
    ack(c); chk("R9 clr_t0 in priority run", c, 4'b0100); t0_ovf = 1'b0;
    tick(); do_reti(); tick();
    chk("R6 ext1 third", irq_vector, 16'h0013);
    ack(c); chk("R9 clr_ext1 edge mode", c, 4'b0010); ext1_flag = 1'b0;
    tick(); do_reti(); tick();
    chk("R6 tmr1 fourth", irq_vector, 16'h001B);
    ack(c); chk("R9 clr_t1", c, 4'b1000); t1_ovf = 1'b0;
    tick(); do_reti(); tick();
    chk("R6 ser fifth", irq_vector, 16'h0023);
    ack(c); chk("R9 no clear for ser", c, 0); ser_flag = 1'b0;
    tick(); do_reti(); tick();
    chk("R6 tmr2 last", irq_vector, 16'h002B);
    chk("R7 tmr2 request present", irq_req, 1);
    ack(c); t2_ext = 1'b0;
    tick(); do_reti(); ticks(3);
    chk("R6 all served", irq_req, 0);
  endtask

  task automatic t_masks();
    logic [3:0] c;
    wr_en(8'h3F);
    ext0_edge = 1'b1; ext0_flag = 1'b1;
    ticks(3); chk("R3 global off masks", irq_req, 0);
    wr_en(8'h80);
    t1_ovf = 1'b1;
    ticks(4); chk("R3 source bits off mask", irq_req, 0);
    t1_ovf = 1'b0; ticks(2);
    wr_en(8'hC1); chk("R2 write with bit6", en_rdata, 8'h81);
    tick(); chk("R11 pending issued on next tick", irq_req, 1);
    chk("R7 ext0 vector", irq_vector, 16'h0003);
    ack(c); ext0_flag = 1'b0; tick(); do_reti(); ticks(2);
  endtask

  task automatic t_level();
    logic [3:0] c;
    wr_en(8'h84);
    ext1_edge = 1'b0; ext1_flag = 1'b1;
    ticks(2); chk("R4 ext1 level req after 2 ticks", irq_req, 1);
    chk("R7 ext1 vector", irq_vector, 16'h0013);
    ack(c); chk("R9 no clear in level mode", c, 0);
    ext1_flag = 1'b0; tick(); do_reti(); ticks(3);
    chk("R9 level source gone", irq_req, 0);
  endtask

  initial begin
    rst_n = 1'b0; mc_tick = 0; ext0_flag = 0; ext1_flag = 0; ext0_edge = 0; ext1_edge = 0;
    t0_ovf = 0; t1_ovf = 0; t2_ovf = 0; t2_ext = 0; ser_flag = 0; en_wr = 0; en_wdata = 0;
    irq_ack = 0; reti = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_enreg();
    t_tmr2_early();
    t_tmr0_late();
    t_priority();
    t_masks();
    t_level();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      done = 1;
      nchk++; nfail++;
      $display("FAIL watchdog: got %0d cycles expected under 20000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule